// File: doc/BRIEF.md
# Procedure Call Stack Sequencer

This block performs the control-transfer half of a procedure call. Once the surrounding core has worked out the call form, the return address and the target operands, it pulses `start`. The sequencer fetches an indirect target from memory if the form needs one. It then pushes the return linkage onto a word-wide downward-growing stack and reports the new stack pointer, code segment and instruction pointer. The end of the work is marked by a one-cycle `done` pulse.

Five call forms are handled. A near call pushes one word, the return offset, and replaces only the instruction pointer. A far call pushes two words, the old segment first and then the return offset, and replaces both segment and offset. The target can be an immediate near offset, an immediate segment:offset pair, a register value, a 16-bit pointer in memory, or a 32-bit pointer in memory. The 32-bit pointer is read as two words. All memory traffic goes through one word-wide port with a request/ready handshake. The address on that port is the byte address of the low byte, so the high byte of each word sits at address+1. Processor flags are not part of this block and are never altered by it.

Top module: `procCallUnit`

## Requirements
- R1: After reset, `busy`, `done`, `memReq` and `memWe` are low, and `newSp`, `newCs` and `newIp` are zero.
- R2: Form code 0 (near, immediate) makes exactly one stack write of `retIp` at address `curSp-2`. The block then ends with `newSp=curSp-2`, `newIp=targetOff` and `newCs=curCs`.
- R3: Form code 1 (far, immediate) writes `curCs` at `curSp-2` and then `retIp` at `curSp-4`. It ends with `newSp=curSp-4`, `newCs=targetSeg` and `newIp=targetOff`. Stack arithmetic wraps modulo 2^16.
- R4: While `memReq` is high and `memReady` is low, `memReq`, `memWe`, `memAddr` and `memWdata` hold steady. A transfer completes at the rising edge where both are high. `memAddr` is the byte address of the low byte of the word.
- R5: Form code 3 (near, register) takes the new offset from `regTarget` and otherwise behaves as in R2.
- R6: Form code 2 (near, 16-bit memory pointer) reads one word at `operandAddr` before any write. That word becomes `newIp`, and the push follows R2.
- R7: Form code 4 (far, 32-bit memory pointer) reads the offset at `operandAddr` and then the segment at `operandAddr+2`. Both reads finish before any write, and the two pushes and the results then follow R3.
- R8: `done` is high for exactly one cycle, the cycle after the final stack write is accepted. At that point `newSp`, `newCs` and `newIp` hold their final values, and they stay unchanged until the next accepted `start`.
- R9: A `start` while `busy` is high is ignored. A `start` with form codes 5 to 7 is ignored, so that no memory request is made and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a call when idle |
| callForm | input | 3 | Call form code (0..4 valid) |
| curSp | input | 16 | Stack pointer before the call |
| curCs | input | 16 | Code segment before the call |
| retIp | input | 16 | Offset of the instruction after the call |
| targetOff | input | 16 | Immediate target offset |
| targetSeg | input | 16 | Immediate target segment |
| regTarget | input | 16 | Register-held target offset |
| operandAddr | input | 16 | Address of the memory pointer operand |
| busy | output | 1 | A call is in progress |
| done | output | 1 | One-cycle completion pulse |
| newSp | output | 16 | Resulting stack pointer |
| newCs | output | 16 | Resulting code segment |
| newIp | output | 16 | Resulting instruction pointer |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 16 | Memory byte address of the low byte |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid with memReady |
| memReady | input | 1 | Memory accepts/completes the request |

## Verification
The bench builds the block with its default 16-bit word width, which makes each push step 2 bytes. It runs every call form twice: once against a memory that accepts at once, and once against a memory that stalls on a repeating pattern. The stalled run is what exercises request holding. With a word width of 16, a stack pointer close to zero can be chosen so that a far call wraps to the top of the address space, and the bench covers that case. Read data is a known function of the address, so the expected pointer results of the indirect forms can be computed ahead of time.

// File: rtl/procCallPkg.sv
package procCallPkg;

  localparam int FORM_BITS = 3;

  typedef enum logic [FORM_BITS-1:0] {
    FORM_NEAR_IMM = 3'd0,
    FORM_FAR_IMM  = 3'd1,
    FORM_NEAR_MEM = 3'd2,
    FORM_NEAR_REG = 3'd3,
    FORM_FAR_MEM  = 3'd4
  } callForm_e;

  typedef enum logic [1:0] {
    ADDR_OPER    = 2'd0,
    ADDR_OPER_HI = 2'd1,
    ADDR_STACK   = 2'd2
  } addrSel_e;

  typedef enum logic {
    WDATA_CS = 1'b0,
    WDATA_IP = 1'b1
  } wdataSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      ldStart;
    logic      pickReg;
    logic      capOff;
    logic      capSeg;
    logic      decSp;
    logic      setIp;
    logic      setCs;
    addrSel_e  addrSel;
    wdataSel_e dataSel;
  } pathCtrl_t;

endpackage

// File: rtl/procCallCtrl.sv
module procCallCtrl
  import procCallPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [FORM_BITS-1:0] callForm,
  input  logic                 memReady,
  output logic                 memReq,
  output logic                 memWe,
  output logic                 busy,
  output logic                 done,
  output pathCtrl_t            strobes
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_OFF, ST_RD_SEG, ST_PUSH_CS, ST_PUSH_IP, ST_DONE
  } state_e;

  state_e    state, stateNext;
  callForm_e formReg;
  logic      formValid;
  logic      isFar;

  assign formValid = (callForm <= FORM_BITS'(FORM_FAR_MEM));
  assign isFar     = (formReg == FORM_FAR_IMM) || (formReg == FORM_FAR_MEM);

  function automatic state_e firstState(input logic [FORM_BITS-1:0] f);
    case (f)
      FORM_FAR_IMM:  return ST_PUSH_CS;
      FORM_NEAR_MEM,
      FORM_FAR_MEM:  return ST_RD_OFF;
      default:       return ST_PUSH_IP;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      formReg <= FORM_NEAR_IMM;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start && formValid)
        formReg <= callForm_e'(callForm);
    end
  end

  always_comb begin
    stateNext       = state;
    memReq          = 1'b0;
    memWe           = 1'b0;
    done            = 1'b0;
    strobes         = '0;
    strobes.addrSel = ADDR_STACK;
    strobes.dataSel = WDATA_IP;
    case (state)
      ST_IDLE: begin
        if (start && formValid) begin
          strobes.ldStart = 1'b1;
          strobes.pickReg = (callForm == FORM_BITS'(FORM_NEAR_REG));
          stateNext       = firstState(callForm);
        end
      end
      ST_RD_OFF: begin
        memReq          = 1'b1;
        strobes.addrSel = ADDR_OPER;
        if (memReady) begin
          strobes.capOff = 1'b1;
          stateNext      = isFar ? ST_RD_SEG : ST_PUSH_IP;
        end
      end
      ST_RD_SEG: begin
        memReq          = 1'b1;
        strobes.addrSel = ADDR_OPER_HI;
        if (memReady) begin
          strobes.capSeg = 1'b1;
          stateNext      = ST_PUSH_CS;
        end
      end
      ST_PUSH_CS: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        strobes.dataSel = WDATA_CS;
        if (memReady) begin
          strobes.decSp = 1'b1;
          stateNext     = ST_PUSH_IP;
        end
      end
      ST_PUSH_IP: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          strobes.decSp = 1'b1;
          strobes.setIp = 1'b1;
          strobes.setCs = isFar;
          stateNext     = ST_DONE;
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R8: completion pulse lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a far pointer read always moves on to reading the segment
  a_r7_seg_follows_off: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_OFF && memReady && formReg == FORM_FAR_MEM) |=> (state == ST_RD_SEG));

endmodule

// File: rtl/procCallPath.sv
module procCallPath
  import procCallPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtrl_t         strobes,
  input  logic [WORD_W-1:0] curSp,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] retIp,
  input  logic [WORD_W-1:0] targetOff,
  input  logic [WORD_W-1:0] targetSeg,
  input  logic [WORD_W-1:0] regTarget,
  input  logic [WORD_W-1:0] operandAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] newSp,
  output logic [WORD_W-1:0] newCs,
  output logic [WORD_W-1:0] newIp
);

  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  logic [WORD_W-1:0] spReg, csReg, ipReg;
  logic [WORD_W-1:0] pushCs, retIpReg, tgtOff, tgtSeg, opAddr;
  logic [WORD_W-1:0] pushAddr;

  assign pushAddr = spReg - STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg    <= '0;
      csReg    <= '0;
      ipReg    <= '0;
      pushCs   <= '0;
      retIpReg <= '0;
      tgtOff   <= '0;
      tgtSeg   <= '0;
      opAddr   <= '0;
    end else begin
      if (strobes.ldStart) begin
        spReg    <= curSp;
        pushCs   <= curCs;
        retIpReg <= retIp;
        tgtOff   <= strobes.pickReg ? regTarget : targetOff;
        tgtSeg   <= targetSeg;
        opAddr   <= operandAddr;
      end
      if (strobes.capOff) tgtOff <= memRdata;
      if (strobes.capSeg) tgtSeg <= memRdata;
      if (strobes.decSp)  spReg  <= pushAddr;
      if (strobes.setIp)  ipReg  <= tgtOff;
      if (strobes.setIp)  csReg  <= strobes.setCs ? tgtSeg : pushCs;
    end
  end

  always_comb begin
    case (strobes.addrSel)
      ADDR_OPER:    memAddr = opAddr;
      ADDR_OPER_HI: memAddr = opAddr + STEP;
      default:      memAddr = pushAddr;
    endcase
    memWdata = (strobes.dataSel == WDATA_CS) ? pushCs : retIpReg;
  end

  assign newSp = spReg;
  assign newCs = csReg;
  assign newIp = ipReg;

  // R2/R3: a stack pointer update always moves down by one word
  a_r3_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decSp && !strobes.ldStart) |=> (newSp + STEP == $past(newSp)));

endmodule

// File: rtl/procCallUnit.sv
module procCallUnit
  import procCallPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [FORM_BITS-1:0] callForm,
  input  logic [WORD_W-1:0]    curSp,
  input  logic [WORD_W-1:0]    curCs,
  input  logic [WORD_W-1:0]    retIp,
  input  logic [WORD_W-1:0]    targetOff,
  input  logic [WORD_W-1:0]    targetSeg,
  input  logic [WORD_W-1:0]    regTarget,
  input  logic [WORD_W-1:0]    operandAddr,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_W-1:0]    newSp,
  output logic [WORD_W-1:0]    newCs,
  output logic [WORD_W-1:0]    newIp,
  output logic                 memReq,
  output logic                 memWe,
  output logic [WORD_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    memWdata,
  input  logic [WORD_W-1:0]    memRdata,
  input  logic                 memReady
);

  pathCtrl_t strobes;

  procCallCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .callForm (callForm),
    .memReady (memReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done),
    .strobes  (strobes)
  );

  procCallPath #(.WORD_W(WORD_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .curSp       (curSp),
    .curCs       (curCs),
    .retIp       (retIp),
    .targetOff   (targetOff),
    .targetSeg   (targetSeg),
    .regTarget   (regTarget),
    .operandAddr (operandAddr),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .newSp       (newSp),
    .newCs       (newCs),
    .newIp       (newIp)
  );

  // R4: a stalled request holds its contents
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  // R8: done comes right after an accepted write
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && memReady && memWe));

  // R7: no read follows a stack write within a call
  a_r7_reads_before_writes: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && memWe) |=> !(memReq && !memWe));

  // R9: memory traffic only while a call is in progress
  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

// File: tb/procCallUnit_tb.sv
module procCallUnit_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] callForm = '0;
  logic [W-1:0] curSp = '0, curCs = '0, retIp = '0, targetOff = '0;
  logic [W-1:0] targetSeg = '0, regTarget = '0, operandAddr = '0;
  logic busy, done, memReq, memWe;
  logic [W-1:0] newSp, newCs, newIp, memAddr, memWdata;
  logic [W-1:0] memRdata = '0;
  logic memReady = 1'b0;

  always #10 clk = ~clk;

  procCallUnit #(.WORD_W(W)) u_dut (.*);

  typedef struct packed { logic we; logic [W-1:0] addr; logic [W-1:0] data; } xfer_t;
  xfer_t expQ[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stallOn = 0;
  bit finished = 0;

  function automatic logic [W-1:0] memFn(input logic [W-1:0] a);
    return a ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory model: decide ready and read data just after each edge
  always @(posedge clk) begin
    cyc++;
    #1;
    memReady = stallOn ? (cyc % 3 != 0) : 1'b1;
    memRdata = memReq ? memFn(memAddr) : '0;
  end

  // monitor: compare each transfer with the scoreboard (R4 ordering)
  always @(negedge clk) begin
    if (rstN && memReq && memReady) begin
      if (expQ.size() == 0) begin
        check(0, "R4 unexpected transfer", memAddr, '0);
      end else begin
        xfer_t e;
        e = expQ.pop_front();
        check(memWe == e.we, "R4/R7 transfer direction", {15'd0, memWe}, {15'd0, e.we});
        check(memAddr == e.addr, "R4 transfer address", memAddr, e.addr);
        if (e.we) check(memWdata == e.data, "R2/R3 pushed word", memWdata, e.data);
      end
    end
  end

  task automatic runCall(input logic [2:0] f, input logic [W-1:0] sp, input logic [W-1:0] cs,
                         input logic [W-1:0] ret, input logic [W-1:0] off, input logic [W-1:0] seg,
                         input logic [W-1:0] rg, input logic [W-1:0] op, input bit interfere,
                         input string req);
    logic [W-1:0] eIp, eCs, eSp;
    bit far;
    int n;
    far = (f == 3'd1) || (f == 3'd4);
    eIp = (f == 3'd3) ? rg : off;
    eCs = far ? seg : cs;
    if (f == 3'd2 || f == 3'd4) begin
      expQ.push_back('{1'b0, op, '0});
      eIp = memFn(op);
    end
    if (f == 3'd4) begin
      expQ.push_back('{1'b0, op + 16'd2, '0});
      eCs = memFn(op + 16'd2);
    end
    eSp = sp;
    if (far) begin
      eSp = eSp - 16'd2;
      expQ.push_back('{1'b1, eSp, cs});
    end
    eSp = eSp - 16'd2;
    expQ.push_back('{1'b1, eSp, ret});

    @(negedge clk);
    callForm = f; curSp = sp; curCs = cs; retIp = ret; targetOff = off;
    targetSeg = seg; regTarget = rg; operandAddr = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      // R9: a start while busy must be ignored
      callForm = 3'd1; curSp = 16'h1234; curCs = 16'hDEAD; retIp = 16'hBEEF;
      targetOff = 16'h7777; targetSeg = 16'h8888; regTarget = 16'h9999; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {req, " done seen"}, {15'd0, done}, 16'd1);
    check(newSp == eSp, {req, " newSp"}, newSp, eSp);
    check(newCs == eCs, {req, " newCs"}, newCs, eCs);
    check(newIp == eIp, {req, " newIp"}, newIp, eIp);
    check(expQ.size() == 0, {req, " all transfers seen"}, W'(expQ.size()), '0);
    expQ.delete();
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", {15'd0, done}, '0);
    check(newIp == eIp && newCs == eCs && newSp == eSp, "R8 outputs held", newIp, eIp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && memReq == 0 && memWe == 0, "R1 control idle",
          {12'd0, busy, done, memReq, memWe}, '0);
    check(newSp == 0 && newCs == 0 && newIp == 0, "R1 outputs zero", newSp | newCs | newIp, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int pass = 0; pass < 2; pass++) begin
      stallOn = (pass == 1);
      runCall(3'd0, 16'h0100, 16'h2000, 16'h0042, 16'h1111, 16'hAAAA, 16'h0, 16'h0, 0, "R2 near imm");
      runCall(3'd1, 16'h0200, 16'h2100, 16'h0050, 16'h2222, 16'h3300, 16'h0, 16'h0, 0, "R3 far imm");
      runCall(3'd3, 16'h0300, 16'h2200, 16'h0060, 16'h4444, 16'h0, 16'h5678, 16'h0, 0, "R5 near reg");
      runCall(3'd2, 16'h0400, 16'h2300, 16'h0070, 16'h0, 16'h0, 16'h0, 16'h0810, 0, "R6 near mem16");
      runCall(3'd4, 16'h0500, 16'h2400, 16'h0080, 16'h0, 16'h0, 16'h0, 16'h0920, 0, "R7 far mem32");
    end

    // R3 wrap-around of the stack pointer
    stallOn = 0;
    runCall(3'd1, 16'h0002, 16'h3000, 16'h0090, 16'h5555, 16'h6600, 16'h0, 16'h0, 0, "R3 sp wrap");
    // R9 start during a call is ignored
    stallOn = 1;
    runCall(3'd4, 16'h0600, 16'h2500, 16'h00A0, 16'h0, 16'h0, 16'h0, 16'h0A30, 1, "R9 busy start");

    // R9 invalid form codes are ignored
    for (int f = 5; f < 8; f++) begin
      logic [W-1:0] sSp, sCs, sIp;
      sSp = newSp; sCs = newCs; sIp = newIp;
      @(negedge clk);
      callForm = 3'(f); curSp = 16'hF000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) begin
        check(busy == 0 && memReq == 0, "R9 invalid form no activity", {14'd0, busy, memReq}, '0);
        @(negedge clk);
      end
      check(newSp == sSp && newCs == sCs && newIp == sIp, "R9 invalid form outputs unchanged", newSp, sSp);
    end

    finishRun();
  end

endmodule